// File: doc/BRIEF.md
# Double-Word Load/Store Unit

This block carries out paired-word transfers between a register pair and a data memory that is twice the register width. A request gives a byte address made of a base plus a scaled index, a load-or-store flag and, for stores, two source words. The pair moves in a single wide memory operation. For a load, both destination words come back together one cycle after the request.

The pair must sit on a boundary of twice the word size: 8 bytes for 32-bit words. A request whose address misses that boundary never reaches memory. Instead, the unit raises a load/store fault one cycle later and reports the full faulting address. No range check is made. An aligned address that runs past the end of a software object, or past the top of the memory, still completes, and the row index simply keeps the low address bits.

The memory sits outside the block. It is a synchronous array with one cycle of read latency, reached through an enable, a write strobe, a row index and the two data buses.

Top module: `dword_lsu`

## Requirements
- R1: After reset, `rsp_valid` and `exc_valid` are low.
- R2: The effective byte address is `req_base + 8*req_index`, taken modulo 2^32. The memory row is bits [ROW_W+2:3] of that address, and higher bits are dropped.
- R3: When address bits [2:0] are not all zero, `exc_valid` pulses high for one cycle in the cycle after the request, and `exc_addr` holds the full effective address.
- R4: An aligned store makes exactly one memory access, with `mem_en` and `mem_we` high in the request cycle. `mem_wdata[31:0]` is `src_b` (the lower-addressed word) and `mem_wdata[63:32]` is `src_a`.
- R5: An aligned load makes one read of the row. In the next cycle `rsp_valid` pulses for one cycle, `dst_b` carries row bits [31:0] (the lower-addressed word) and `dst_a` carries bits [63:32].
- R6: A misaligned request of either kind drives no memory enable and no write, and produces no `rsp_valid`. The memory contents stay unchanged.
- R7: No bounds check is made. An aligned access to the highest memory row, or one reached from a large base, completes normally with no fault.
- R8: Requests may arrive on consecutive cycles. Each request is handled by itself, and a load that follows a store to the same row returns the newly stored pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store pair, 0 = load pair |
| req_base | input | ADDR_W | Base byte address |
| req_index | input | IDX_W | Index, scaled by the pair size |
| src_a | input | WORD_W | First source word (goes to the higher address) |
| src_b | input | WORD_W | Second source word (goes to the lower address) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_row | output | ROW_W | Memory row index |
| mem_wdata | output | 2*WORD_W | Wide write data |
| mem_rdata | input | 2*WORD_W | Wide read data, one cycle after the enable |
| rsp_valid | output | 1 | Load result valid pulse |
| dst_a | output | WORD_W | First destination (higher-addressed word) |
| dst_b | output | WORD_W | Second destination (lower-addressed word) |
| exc_valid | output | 1 | Load/store fault pulse |
| exc_addr | output | ADDR_W | Faulting effective address |

## Verification
A fault report and a fresh memory access can occupy the same cycle. The registered fault of one request is on the outputs while the next, aligned request already drives the memory enable. The bench provokes this by issuing a misaligned load immediately followed by an aligned load. In that second cycle it checks the fault flag and address together with the enable and row of the new access, and in the cycle after that it checks the load data. A load response can also coincide with a store to the same row. That case is judged by requiring that a load issued right after a store returns the stored pair.

// File: rtl/dword_lsu_pkg.sv
package dword_lsu_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_FAULT = 2'd3
   } acc_kind_e;

   // address bits that must be zero for a pair of words of the given width
   function automatic int pair_align_bits(input int word_w);
      return $clog2(word_w / 4);
   endfunction

endpackage

// File: rtl/dword_lsu_agen.sv
module dword_lsu_agen #(
   parameter int ADDR_W       = 32,
   parameter int IDX_W        = 16,
   parameter int ALIGN_BITS   = 3,
   parameter int ROW_W        = 10,
   parameter bit INDEX_SCALED = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  index,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              aligned,
   output logic [ROW_W-1:0]  row
);
   logic [ADDR_W-1:0] offset;

   generate
      if (INDEX_SCALED) begin : g_scaled
         assign offset = ADDR_W'(index) << ALIGN_BITS;
      end else begin : g_byte
         assign offset = ADDR_W'(index);
      end
   endgenerate

   assign eff_addr = base + offset;
   assign aligned  = (eff_addr[ALIGN_BITS-1:0] == '0);
   assign row      = eff_addr[ALIGN_BITS +: ROW_W];
endmodule

// File: rtl/dword_lsu_lanes.sv
module dword_lsu_lanes #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]   src_first,
   input  logic [WORD_W-1:0]   src_second,
   output logic [2*WORD_W-1:0] wide_wdata,
   input  logic [2*WORD_W-1:0] wide_rdata,
   output logic [WORD_W-1:0]   dst_first,
   output logic [WORD_W-1:0]   dst_second
);
   // lower address holds the second operand, upper address the first
   assign wide_wdata = {src_first, src_second};
   assign dst_second = wide_rdata[WORD_W-1:0];
   assign dst_first  = wide_rdata[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/dword_lsu_resp.sv
module dword_lsu_resp
   import dword_lsu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind,
   input  logic [ADDR_W-1:0] eff_addr,
   output logic              rsp_valid,
   output logic              exc_valid,
   output logic [ADDR_W-1:0] exc_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         exc_valid <= 1'b0;
         exc_addr  <= '0;
      end else begin
         rsp_valid <= (kind == ACC_LOAD);
         exc_valid <= (kind == ACC_FAULT);
         if (kind == ACC_FAULT) begin
            exc_addr <= eff_addr;
         end
      end
   end
endmodule

// File: rtl/dword_lsu.sv
module dword_lsu
   import dword_lsu_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int IDX_W        = 16,
   parameter int WORD_W       = 32,
   parameter int ROW_W        = 10,
   parameter bit INDEX_SCALED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [ADDR_W-1:0]   req_base,
   input  logic [IDX_W-1:0]    req_index,
   input  logic [WORD_W-1:0]   src_a,
   input  logic [WORD_W-1:0]   src_b,
   output logic                mem_en,
   output logic                mem_we,
   output logic [ROW_W-1:0]    mem_row,
   output logic [2*WORD_W-1:0] mem_wdata,
   input  logic [2*WORD_W-1:0] mem_rdata,
   output logic                rsp_valid,
   output logic [WORD_W-1:0]   dst_a,
   output logic [WORD_W-1:0]   dst_b,
   output logic                exc_valid,
   output logic [ADDR_W-1:0]   exc_addr
);
   localparam int ALIGN_BITS = pair_align_bits(WORD_W);

   generate
      if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("WORD_W must be a power of two of at least 8");
      end
      if (IDX_W > ADDR_W) begin : g_bad_idx
         $error("IDX_W must not exceed ADDR_W");
      end
      if (ALIGN_BITS + ROW_W > ADDR_W) begin : g_bad_row
         $error("ROW_W too wide for ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_addr;
   logic              aligned;
   acc_kind_e         kind;

   dword_lsu_agen #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS),
      .ROW_W(ROW_W), .INDEX_SCALED(INDEX_SCALED)
   ) u_agen (
      .base(req_base), .index(req_index),
      .eff_addr(eff_addr), .aligned(aligned), .row(mem_row)
   );

   always_comb begin
      if (!req_valid)     kind = ACC_IDLE;
      else if (!aligned)  kind = ACC_FAULT;
      else if (req_store) kind = ACC_STORE;
      else                kind = ACC_LOAD;
   end

   assign mem_en = (kind == ACC_LOAD) || (kind == ACC_STORE);
   assign mem_we = (kind == ACC_STORE);

   dword_lsu_lanes #(.WORD_W(WORD_W)) u_lanes (
      .src_first(src_a), .src_second(src_b), .wide_wdata(mem_wdata),
      .wide_rdata(mem_rdata), .dst_first(dst_a), .dst_second(dst_b)
   );

   dword_lsu_resp #(.ADDR_W(ADDR_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .kind(kind), .eff_addr(eff_addr),
      .rsp_valid(rsp_valid), .exc_valid(exc_valid), .exc_addr(exc_addr)
   );
endmodule

// File: rtl/dword_lsu_chk.sv
module dword_lsu_chk #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_store,
   input logic [WORD_W-1:0]   src_a,
   input logic [WORD_W-1:0]   src_b,
   input logic                mem_en,
   input logic                mem_we,
   input logic [2*WORD_W-1:0] mem_wdata,
   input logic [2*WORD_W-1:0] mem_rdata,
   input logic                rsp_valid,
   input logic [WORD_W-1:0]   dst_a,
   input logic [WORD_W-1:0]   dst_b,
   input logic                exc_valid,
   input logic [ADDR_W-1:0]   exc_addr
);
   p_fault_from_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> $past(req_valid) && !$past(mem_en));

   p_fault_addr_misaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_addr[2:0] != 3'b000));

   p_mem_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> req_valid);

   p_write_only_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en && req_store);

   p_store_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == {src_a, src_b}));

   p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(mem_en) && !$past(mem_we));

   p_load_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (dst_a == mem_rdata[2*WORD_W-1:WORD_W]) && (dst_b == mem_rdata[WORD_W-1:0]));

   p_no_rsp_with_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && exc_valid));
endmodule

bind dword_lsu dword_lsu_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/dword_lsu_bench.sv
module dword_lsu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ROWS_W = 4;
   localparam int NROWS = 1 << ROWS_W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [31:0] req_base = '0;
   logic [15:0] req_index = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic        mem_en, mem_we;
   logic [ROWS_W-1:0] mem_row;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata;
   logic        rsp_valid, exc_valid;
   logic [31:0] dst_a, dst_b, exc_addr;

   logic [63:0] mem_q   [NROWS];
   logic [63:0] exp_mem [NROWS];
   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dword_lsu #(.ROW_W(ROWS_W)) u_dword_lsu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_base(req_base), .req_index(req_index), .src_a(src_a), .src_b(src_b),
      .mem_en(mem_en), .mem_we(mem_we), .mem_row(mem_row), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .dst_a(dst_a), .dst_b(dst_b),
      .exc_valid(exc_valid), .exc_addr(exc_addr)
   );

   // synchronous memory with one cycle of read latency
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem_q[mem_row] <= mem_wdata;
         else        mem_rdata <= mem_q[mem_row];
      end
   end

   function automatic logic [31:0] pat_a(input int r, input int s);
      return 32'hA100_0000 + 32'(r) * 32'h0001_0101 + 32'(s) * 32'h0100_0000;
   endfunction
   function automatic logic [31:0] pat_b(input int r, input int s);
      return 32'h5E00_0000 + 32'(r) * 32'h0002_0003 + 32'(s) * 32'h0010_0000;
   endfunction
   function automatic logic [31:0] ea(input logic [31:0] b, input logic [15:0] i);
      return b + {13'd0, i, 3'b000};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic st, input logic [31:0] b, input logic [15:0] i,
                        input logic [31:0] a, input logic [31:0] bb);
      req_valid = 1'b1; req_store = st; req_base = b; req_index = i;
      src_a = a; src_b = bb;
   endtask

   task automatic idle();
      req_valid = 1'b0; req_store = 1'b0;
   endtask

   // aligned store; checks the memory port in the request cycle
   task automatic do_store(input logic [31:0] b, input logic [15:0] i,
                           input logic [31:0] a, input logic [31:0] bb);
      logic [ROWS_W-1:0] r;
      r = ea(b, i)[ROWS_W+2:3];
      @(negedge clk);
      drive(1'b1, b, i, a, bb);
      #1;
      check("R4 store enable/write", {62'd0, mem_en, mem_we}, 64'd3);
      check("R2 store row", 64'(mem_row), 64'(r));
      check("R4 store wide data order", mem_wdata, {a, bb});
      exp_mem[r] = {a, bb};
      @(negedge clk);
      idle();
      check("R4 no response/fault after store", {62'd0, rsp_valid, exc_valid}, 64'd0);
   endtask

   task automatic do_load(input logic [31:0] b, input logic [15:0] i, input string tag);
      logic [ROWS_W-1:0] r;
      r = ea(b, i)[ROWS_W+2:3];
      @(negedge clk);
      drive(1'b0, b, i, 32'hDEAD_0001, 32'hDEAD_0002);
      #1;
      check({tag, " R5 load enable"}, {62'd0, mem_en, mem_we}, 64'd2);
      @(negedge clk);
      idle();
      check({tag, " R5 rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
      check({tag, " R5 dst_a upper word"}, 64'(dst_a), 64'(exp_mem[r][63:32]));
      check({tag, " R5 dst_b lower word"}, 64'(dst_b), 64'(exp_mem[r][31:0]));
      check({tag, " R6 no fault on aligned"}, {63'd0, exc_valid}, 64'd0);
      @(negedge clk);
      check({tag, " R5 rsp pulse ends"}, {63'd0, rsp_valid}, 64'd0);
   endtask

   task automatic do_fault(input logic st, input logic [31:0] b, input logic [15:0] i);
      @(negedge clk);
      drive(st, b, i, 32'hBAD0_BAD0, 32'h0BAD_0BAD);
      #1;
      check("R6 misaligned no mem access", {62'd0, mem_en, mem_we}, 64'd0);
      @(negedge clk);
      idle();
      check("R3 fault pulse", {63'd0, exc_valid}, 64'd1);
      check("R3 fault address", 64'(exc_addr), 64'(ea(b, i)));
      check("R6 no rsp on fault", {63'd0, rsp_valid}, 64'd0);
      @(negedge clk);
      check("R3 fault pulse ends", {63'd0, exc_valid}, 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < NROWS; k++) begin
         mem_q[k] = '0;
         exp_mem[k] = '0;
      end
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {62'd0, rsp_valid, exc_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {62'd0, rsp_valid, exc_valid}, 64'd0);

      // R2/R4: fill every row, address carried by index only
      for (int r = 0; r < NROWS; r++) do_store(32'd0, 16'(r), pat_a(r, 0), pat_b(r, 0));
      // R2/R5: read back with split base/index
      for (int r = 0; r < NROWS; r++)
         do_load(32'((r & 3) << 3), 16'(r & ~3), "sweep");

      // R3/R6: every misaligned offset, stores and loads
      for (int off = 1; off < 8; off++) begin
         do_fault(1'b1, 32'(24 + off), 16'd1);
         do_fault(1'b0, 32'(8 * off + off), 16'd2);
      end
      do_load(32'd32, 16'd0, "R6 row4 untouched");
      do_load(32'd0, 16'd5, "R6 row5 untouched");

      // R2: upper address bits dropped, 0x80 maps to row 0
      do_store(32'h0000_0080, 16'd0, pat_a(0, 1), pat_b(0, 1));
      do_load(32'd0, 16'd0, "R2 wrap row0");
      // R7: top row from a large base completes without fault
      do_store(32'hFFFF_FFF8, 16'd0, pat_a(15, 2), pat_b(15, 2));
      do_load(32'h0000_0000, 16'd15, "R7 top row");

      // R8: misaligned load then aligned load back to back
      @(negedge clk);
      drive(1'b0, 32'd20, 16'd0, '0, '0);
      @(negedge clk);
      drive(1'b0, 32'd0, 16'd5, '0, '0);
      #1;
      check("R8 fault while next access", {62'd0, exc_valid, mem_en}, 64'd3);
      check("R8 fault address", 64'(exc_addr), 64'd20);
      check("R8 next row", 64'(mem_row), 64'd5);
      @(negedge clk);
      idle();
      check("R8 rsp after fault", {62'd0, rsp_valid, exc_valid}, 64'd2);
      check("R8 load data", {dst_a, dst_b}, exp_mem[5]);

      // R8: store then load of the same row on consecutive cycles
      @(negedge clk);
      drive(1'b1, 32'd48, 16'd0, 32'h1234_5678, 32'h9ABC_DEF0);
      @(negedge clk);
      drive(1'b0, 32'd40, 16'd1, '0, '0);
      @(negedge clk);
      idle();
      check("R8 load after store", {dst_a, dst_b}, 64'h1234_5678_9ABC_DEF0);
      check("R8 rsp_valid", {63'd0, rsp_valid}, 64'd1);

      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule